// File: doc/BRIEF.md
# Slow-Domain Register Write Synchronizer

This block carries register writes from a fast bus clock into a low-power domain clocked at 32.768 kHz. A bus write to any ordinary address is captured and held. It is applied to the slow-domain registers only after a fixed number of rising edges of the slow clock have been seen. The slow clock arrives as a plain input. It passes through a short flop chain in the bus clock domain, and its rising edges are detected there. The whole block therefore runs on the bus clock.

Software follows each write through four status bits. Bit 10 is busy, bit 9 is next, bit 8 is complete and bit 7 is error. Software may also take an interrupt when a write completes or when a write is rejected. Reading the status register clears the complete bit. A write that arrives while another is still in flight is dropped and raises the error bit. That bit is cleared by a synchronized write of a 1 to bit 7 of the status address. The interrupt-enable register is the one exception to synchronization: it is written at bus speed.

Top module: `slow_wr_sync`

## Requirements
- R1: After reset, the status word reads 0x200, meaning only bit 9 (next) is set. The interrupt output is low and no update pulse is issued.
- R2: A write strobe to any address other than the interrupt-enable address, while bit 10 (busy) is 0, sets busy on the following cycle. Bit 9 (next) is always the inverse of busy.
- R3: An accepted write is applied on the 4th detected slow-clock rising edge after acceptance, counting only edges seen while busy. Edges are detected after a two-flop synchronizer and compare the 2nd and 3rd samples. The write appears as `regWrEn` high for exactly one cycle, with the captured address and data, and busy falls in that same cycle.
- R4: Bit 8 (complete) is set in the cycle in which the update pulse is visible. It stays set until it is cleared by a status read.
- R5: A status read strobe clears bit 8 on the next cycle. If a completion happens in the same cycle as the read, the completion wins and bit 8 stays set.
- R6: A write strobe to any address other than the interrupt-enable address, while busy, is dropped: the pending write keeps its address and data. The strobe sets bit 7 (error) on the next cycle.
- R7: Bit 7 is cleared only when a synchronized write to the status address with data bit 7 = 1 completes. It is unaffected by status reads and by status writes with data bit 7 = 0. A new rejection in the same cycle as the clearing completion keeps it set.
- R8: A write to the interrupt-enable address is stored on the next cycle, whether or not a write is in flight. It never changes busy, complete or error, and never produces an update pulse. Its data bit 8 enables the complete interrupt and data bit 7 enables the error interrupt.
- R9: `irqOut` is high exactly when (complete AND complete-enable) OR (error AND error-enable) holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slowClk | input | 1 | 32.768 kHz low-power clock, sampled as data |
| wrEn | input | 1 | Bus write strobe |
| wrAddr | input | AW (8) | Bus write address |
| wrData | input | DW (32) | Bus write data |
| stRdEn | input | 1 | Status-register read strobe |
| regWrEn | output | 1 | One-cycle slow-domain register update strobe |
| regWrAddr | output | AW (8) | Address of the applied write |
| regWrData | output | DW (32) | Data of the applied write |
| statusOut | output | DW (32) | Status word, bits 10/9/8/7 = busy/next/complete/error |
| irqOut | output | 1 | Write-complete / write-error interrupt |

## Verification
The bound checker covers the cycle-level rules on every clock:
- busy rises after an accepted strobe;
- a rejected strobe raises error;
- the update pulse lasts one cycle, follows busy and coincides with complete;
- complete falls only after a read;
- error falls only on the completion of a clearing status write.

Only the bench scenarios, compared cycle by cycle with a behavioural model, show the rest:
- the exact four-edge latency against a free-running slow clock;
- that a dropped write leaves the captured data intact;
- the read-versus-completion race;
- interrupt masking through the bus-speed enable register.

// File: rtl/slow_wr_sync_pkg.sv
package slow_wr_sync_pkg;
  localparam int BUSY_BIT = 10;
  localparam int NEXT_BIT = 9;
  localparam int CMP_BIT  = 8;
  localparam int ERR_BIT  = 7;

  typedef struct packed {
    logic accept;   // write captured, synchronization starts
    logic commit;   // synchronized write takes effect now
    logic overlap;  // write arrived while busy
    logic ienWr;    // bus-speed interrupt-enable write
    logic busy;     // a write is in flight
  } ctrlStrobes_t;
endpackage

// File: rtl/slow_wr_sync_ctrl.sv
module slow_wr_sync_ctrl
  import slow_wr_sync_pkg::*;
#(
  parameter int AW = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SYNC_EDGES = 4,
  parameter logic [AW-1:0] IEN_ADDR = 8'h24
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          slowClk,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  output ctrlStrobes_t  strobes
);
  localparam int CW = (SYNC_EDGES > 1) ? $clog2(SYNC_EDGES) : 1;
  localparam logic [CW-1:0] LAST_EDGE = CW'(SYNC_EDGES - 1);

  logic [SYNC_STAGES:0] syncQ;
  logic slowRise;
  logic busyQ;
  logic [CW-1:0] edgeCnt;
  logic isIen;

  // synchronizer chain plus one history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], slowClk};
  end

  assign slowRise = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];
  assign isIen    = (wrAddr == IEN_ADDR);

  always_comb begin
    strobes.accept  = wrEn && !isIen && !busyQ;
    strobes.overlap = wrEn && !isIen && busyQ;
    strobes.ienWr   = wrEn && isIen;
    strobes.commit  = busyQ && slowRise && (edgeCnt == LAST_EDGE);
    strobes.busy    = busyQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      edgeCnt <= '0;
    end else if (strobes.accept) begin
      busyQ   <= 1'b1;
      edgeCnt <= '0;
    end else if (strobes.commit) begin
      busyQ   <= 1'b0;
      edgeCnt <= '0;
    end else if (busyQ && slowRise) begin
      edgeCnt <= edgeCnt + 1'b1;
    end
  end
endmodule

// File: rtl/slow_wr_sync_dpath.sv
module slow_wr_sync_dpath
  import slow_wr_sync_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] STAT_ADDR = 8'h20
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobes_t  strobes,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          stRdEn,
  output logic          regWrEn,
  output logic [AW-1:0] regWrAddr,
  output logic [DW-1:0] regWrData,
  output logic [DW-1:0] statusOut,
  output logic          irqOut
);
  logic [AW-1:0] latAddr;
  logic [DW-1:0] latData;
  logic cmpFlag, errFlag;
  logic cmpIe, errIe;
  logic errClear;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latAddr <= '0;
      latData <= '0;
    end else if (strobes.accept) begin
      latAddr <= wrAddr;
      latData <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regWrEn   <= 1'b0;
      regWrAddr <= '0;
      regWrData <= '0;
    end else begin
      regWrEn <= strobes.commit;
      if (strobes.commit) begin
        regWrAddr <= latAddr;
        regWrData <= latData;
      end
    end
  end

  assign errClear = strobes.commit && (latAddr == STAT_ADDR) && latData[ERR_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpFlag <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (strobes.commit)  cmpFlag <= 1'b1;
      else if (stRdEn)     cmpFlag <= 1'b0;
      if (strobes.overlap) errFlag <= 1'b1;
      else if (errClear)   errFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpIe <= 1'b0;
      errIe <= 1'b0;
    end else if (strobes.ienWr) begin
      cmpIe <= wrData[CMP_BIT];
      errIe <= wrData[ERR_BIT];
    end
  end

  always_comb begin
    statusOut           = '0;
    statusOut[BUSY_BIT] = strobes.busy;
    statusOut[NEXT_BIT] = ~strobes.busy;
    statusOut[CMP_BIT]  = cmpFlag;
    statusOut[ERR_BIT]  = errFlag;
  end

  assign irqOut = (cmpFlag & cmpIe) | (errFlag & errIe);
endmodule

// File: rtl/slow_wr_sync.sv
module slow_wr_sync
  import slow_wr_sync_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int SYNC_STAGES = 2,
  parameter int SYNC_EDGES = 4,
  parameter logic [AW-1:0] STAT_ADDR = 8'h20,
  parameter logic [AW-1:0] IEN_ADDR = 8'h24
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          slowClk,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          stRdEn,
  output logic          regWrEn,
  output logic [AW-1:0] regWrAddr,
  output logic [DW-1:0] regWrData,
  output logic [DW-1:0] statusOut,
  output logic          irqOut
);
  ctrlStrobes_t strobes;

  slow_wr_sync_ctrl #(
    .AW(AW), .SYNC_STAGES(SYNC_STAGES), .SYNC_EDGES(SYNC_EDGES), .IEN_ADDR(IEN_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .slowClk(slowClk),
    .wrEn(wrEn), .wrAddr(wrAddr), .strobes(strobes)
  );

  slow_wr_sync_dpath #(
    .AW(AW), .DW(DW), .STAT_ADDR(STAT_ADDR)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrAddr(wrAddr), .wrData(wrData), .stRdEn(stRdEn),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .statusOut(statusOut), .irqOut(irqOut)
  );
endmodule

// File: rtl/slow_wr_sync_chk.sv
module slow_wr_sync_chk #(
  parameter int AW = 8,
  parameter logic [AW-1:0] STAT_ADDR = 8'h20,
  parameter logic [AW-1:0] IEN_ADDR = 8'h24
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrEn,
  input logic [AW-1:0] wrAddr,
  input logic          stRdEn,
  input logic          regWrEn,
  input logic [AW-1:0] regWrAddr,
  input logic          regErrBit,
  input logic          busyBit,
  input logic          cmpBit,
  input logic          errBit
);
  // R2
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != IEN_ADDR && !busyBit) |=> busyBit);

  // R3
  update_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> ($past(busyBit) && !busyBit));

  // R3
  update_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R4
  update_sets_complete_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> cmpBit);

  // R5
  complete_clear_by_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmpBit) |-> $past(stRdEn));

  // R6
  overlap_sets_error_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != IEN_ADDR && busyBit) |=> errBit);

  // R7
  error_clear_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(errBit) |-> (regWrEn && regWrAddr == STAT_ADDR && regErrBit));

  // R8
  ien_write_no_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == IEN_ADDR && !busyBit) |=> (!busyBit && !regWrEn));
endmodule

bind slow_wr_sync slow_wr_sync_chk #(
  .AW(AW), .STAT_ADDR(STAT_ADDR), .IEN_ADDR(IEN_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .stRdEn(stRdEn),
  .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regErrBit(regWrData[7]),
  .busyBit(statusOut[10]), .cmpBit(statusOut[8]), .errBit(statusOut[7])
);

// File: tb/slow_wr_sync_bench.sv
`timescale 1ns/1ps
module slow_wr_sync_bench;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [AW-1:0] STAT = 8'h20;
  localparam logic [AW-1:0] IEN  = 8'h24;

  logic clk = 1'b0, rstN = 1'b0, slowClk = 1'b0;
  logic wrEn = 1'b0, stRdEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic regWrEn, irqOut;
  logic [AW-1:0] regWrAddr;
  logic [DW-1:0] regWrData, statusOut;

  int vecs = 0;
  int fails = 0;

  slow_wr_sync u_slow_wr_sync (
    .clk(clk), .rstN(rstN), .slowClk(slowClk), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .stRdEn(stRdEn), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .statusOut(statusOut), .irqOut(irqOut)
  );

  always #4 clk = ~clk;  // 125 MHz

  // slow clock: 16 bus cycles per period, toggled away from the active edge
  always begin
    repeat (8) @(negedge clk);
    slowClk = ~slowClk;
  end

  // behavioural reference model
  int hist[3];
  bit mBusy, mCmp, mErr, mCie, mEie, mUpd;
  int mCnt;
  logic [AW-1:0] mLatA, mUpdA;
  logic [DW-1:0] mLatD, mUpdD;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist = '{0, 0, 0};
      mBusy = 0; mCmp = 0; mErr = 0; mCie = 0; mEie = 0; mUpd = 0; mCnt = 0;
      mLatA = '0; mUpdA = '0; mLatD = '0; mUpdD = '0;
    end else begin
      bit rise, ienW, acc, ovl, com, clr;
      rise = (hist[1] == 1) && (hist[2] == 0);
      ienW = wrEn && (wrAddr == IEN);
      acc  = wrEn && (wrAddr != IEN) && !mBusy;
      ovl  = wrEn && (wrAddr != IEN) && mBusy;
      com  = mBusy && rise && (mCnt == 3);
      clr  = com && (mLatA == STAT) && mLatD[7];
      mUpd = com;
      if (com) begin mUpdA = mLatA; mUpdD = mLatD; end
      if (com) mCmp = 1; else if (stRdEn) mCmp = 0;
      if (ovl) mErr = 1; else if (clr) mErr = 0;
      if (ienW) begin mCie = wrData[8]; mEie = wrData[7]; end
      if (acc) begin mBusy = 1; mCnt = 0; mLatA = wrAddr; mLatD = wrData; end
      else if (com) begin mBusy = 0; mCnt = 0; end
      else if (mBusy && rise) mCnt = mCnt + 1;
      hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = slowClk ? 1 : 0;
    end
  end

  function automatic logic [DW-1:0] expStatus();
    logic [DW-1:0] s = '0;
    s[10] = mBusy; s[9] = !mBusy; s[8] = mCmp; s[7] = mErr;
    return s;
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      vecs++;
      if (statusOut[10:9] !== expStatus() >> 9 & 2'b11 || statusOut[10:9] !== {mBusy, !mBusy}) begin
        fails++;
        $display("FAIL R2 busy/next act=%b exp=%b", statusOut[10:9], {mBusy, !mBusy});
      end
      if (statusOut[8] !== mCmp) begin
        fails++;
        $display("FAIL R4/R5 complete act=%b exp=%b", statusOut[8], mCmp);
      end
      if (statusOut[7] !== mErr) begin
        fails++;
        $display("FAIL R6/R7 error act=%b exp=%b", statusOut[7], mErr);
      end
      if (irqOut !== ((mCmp && mCie) || (mErr && mEie))) begin
        fails++;
        $display("FAIL R9 irq act=%b exp=%b", irqOut, (mCmp && mCie) || (mErr && mEie));
      end
      if (regWrEn !== mUpd || (mUpd && (regWrAddr !== mUpdA || regWrData !== mUpdD))) begin
        fails++;
        $display("FAIL R3 update act=%b/%h/%h exp=%b/%h/%h",
                 regWrEn, regWrAddr, regWrData, mUpd, mUpdA, mUpdD);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic statusRead();
    @(negedge clk);
    stRdEn = 1'b1;
    @(negedge clk);
    stRdEn = 1'b0;
  endtask

  // returns at the negedge where the update pulse is visible
  task automatic waitUpdate(output int cyc);
    cyc = 0;
    while (!regWrEn && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    finishRun();
  end

  initial begin
    int cyc;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // r1_reset state
    check(statusOut == 32'h200 && !irqOut && !regWrEn, "R1 reset", statusOut, 32'h200);

    // R2 / R3 / R4: single synchronized write
    busWrite(8'h04, 32'hCAFE_0001);
    check(statusOut[10] && !statusOut[9], "R2 busy after accept", statusOut, 32'h400);
    waitUpdate(cyc);
    check(regWrEn && regWrAddr == 8'h04 && regWrData == 32'hCAFE_0001,
          "R3 update data", regWrData, 32'hCAFE_0001);
    check(cyc >= 48 && cyc <= 70, "R3 latency window", cyc, 64);
    check(statusOut[8] && !statusOut[10], "R4 complete at update", statusOut, 32'h300);
    repeat (5) @(negedge clk);
    check(statusOut[8], "R4 complete held", statusOut, 32'h300);

    // R5: read clears complete
    statusRead();
    check(!statusOut[8], "R5 read clears complete", statusOut, 32'h200);

    // R8 / R9: enable complete interrupt at bus speed
    busWrite(IEN, 32'h0000_0100);
    check(!statusOut[10] && !regWrEn && !irqOut, "R8 ien no sync", statusOut, 32'h200);
    busWrite(8'h08, 32'h0000_1234);
    waitUpdate(cyc);
    check(irqOut, "R9 complete irq", irqOut, 1);
    statusRead();
    check(!irqOut, "R9 irq drops after read", irqOut, 0);

    // R6: overlapping write dropped, error set
    busWrite(8'h0C, 32'h1111_1111);
    busWrite(8'h10, 32'h2222_2222);
    check(statusOut[7] && !irqOut, "R6 error set, not enabled", statusOut, 32'h480);
    // R8: ien write while busy is not an error and takes effect
    busWrite(IEN, 32'h0000_0080);
    check(irqOut && statusOut[10], "R8 ien while busy", irqOut, 1);
    waitUpdate(cyc);
    check(regWrAddr == 8'h0C && regWrData == 32'h1111_1111, "R6 first write kept",
          regWrData, 32'h1111_1111);
    repeat (40) @(negedge clk);
    check(!regWrEn && !statusOut[10], "R6 no second update", statusOut, 32'h380);

    // R7: read and bit7=0 write do not clear error
    statusRead();
    check(statusOut[7], "R7 read keeps error", statusOut, 32'h280);
    busWrite(STAT, 32'h0000_0100);
    waitUpdate(cyc);
    check(statusOut[7], "R7 zero write keeps error", statusOut, 32'h380);
    busWrite(STAT, 32'h0000_0080);
    waitUpdate(cyc);
    check(!statusOut[7] && !irqOut, "R7 one write clears error", statusOut, 32'h300);

    // R5: read held across completion, completion wins
    busWrite(IEN, 32'h0);
    busWrite(8'h14, 32'hABCD_0000);
    @(negedge clk);
    stRdEn = 1'b1;
    waitUpdate(cyc);
    check(statusOut[8], "R5 completion beats read", statusOut, 32'h300);
    @(negedge clk);
    stRdEn = 1'b0;
    check(!statusOut[8], "R5 read clears after race", statusOut, 32'h200);

    // back-to-back writes with varied slow-clock phase
    for (int i = 0; i < 6; i++) begin
      repeat (i * 3) @(negedge clk);
      busWrite(8'h30 + 8'(i), 32'h5A00_0000 + i);
      waitUpdate(cyc);
      check(regWrData == 32'h5A00_0000 + i, "R3 phase sweep", regWrData, 32'h5A00_0000 + i);
    end
    repeat (10) @(negedge clk);
    finishRun();
  end
endmodule